// File: doc/BRIEF.md
# Two-Pattern Stream Matcher with Shared Infix

This block scans a byte stream, one byte per clock when the input valid is high, for two fixed strings: "abcdef" (pattern 0) and "cdcdeg" (pattern 1). Both strings contain the three-character run "cde". One tracker finds that run for both patterns. Each pattern keeps its own short prefix tracker and its own single-character suffix check.

Sharing the infix tracker alone would lose track of which prefix came before a given "cde". Each pattern therefore delays its prefix-found bit through a shift register as long as the infix (three stages). That delayed bit is combined with the shared infix hit. The pattern's suffix check is armed only when this pattern's own prefix sat directly in front of the infix.

Every byte is decoded once into one-hot symbol lines that all trackers share. The per-pattern match flags feed a registered encoder, which reports a valid bit, the index of the lowest-numbered pattern that matched, and the raw flag vector.

Top module: `infix_share_matcher`

## Requirements
- R1: A synchronous reset clears all outputs (hit_valid=0, hit_idx=0, hit_vec=0) on the following cycle. It also discards every partially matched prefix, infix and delayed prefix, so bytes sent before the reset never complete a match after it.
- R2: When the last six accepted bytes are "abcdef", hit_vec bit 0 rises for one cycle. This happens after the second rising edge following the edge that samples the final "f".
- R3: When the last six accepted bytes are "cdcdeg", hit_vec bit 1 rises for one cycle, with the same two-edge latency as R2.
- R4: The stream "abcdeg" gives no hit for either pattern, even though the shared infix "cde" follows pattern 0's prefix.
- R5: Overlapping occurrences are found. In "cdcdcdeg" the match starts at the second "cd" and is reported. Back-to-back patterns with no gap are each reported.
- R6: A cycle with in_valid low consumes no byte and causes no hit. A pattern whose bytes are separated by idle cycles still matches, and its hit follows its final byte with the R2 latency.
- R7: hit_valid is the OR of hit_vec. hit_idx is the lowest set bit position of hit_vec (0 for "abcdef", 1 for "cdcdeg"), and is 0 when no bit is set.
- R8: Any accepted byte that breaks a pattern, including bytes outside "a" to "g", ends that partial match. "abcxdef" gives no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered on in_data this cycle |
| in_data | input | 8 | Stream byte |
| hit_valid | output | 1 | At least one pattern completed |
| hit_idx | output | 1 | Lowest-numbered pattern that completed |
| hit_vec | output | 2 | One flag per pattern, bit 0 = "abcdef", bit 1 = "cdcdeg" |

## Verification
The decoy "abcdeg" is the key corner case. A design that credited the shared infix to any pattern would report pattern 1 on it. Overlapping input such as "cdcdcdeg" catches a design that restarts tracking only after a failed attempt; such a design would miss the match. Idle gaps in the middle of patterns catch a design whose delay line shifts every clock instead of every byte; it would drop matches or misplace them. A reset between "abcde" and "f" catches a delay or arm bit that survives reset, which would show up as a phantom pattern 0 hit.

// File: rtl/ism_pkg.sv
package ism_pkg;
    localparam int NSYM = 7;
    localparam logic [7:0] SYM_BASE = "a";
    localparam int NPAT = 2;
    localparam int PRE_LEN = 2;
    localparam int INF_LEN = 3;
    localparam int IDX_W = (NPAT > 1) ? $clog2(NPAT) : 1;
    // element 0 is pattern 0
    localparam logic [NPAT-1:0][8*PRE_LEN-1:0] PRE_SEQS = {"cd", "ab"};
    localparam logic [8*INF_LEN-1:0] INF_SEQ = "cde";
    localparam logic [NPAT-1:0][7:0] SFX_CHARS = {"g", "f"};
    typedef logic [NSYM-1:0] sym_t;
endpackage

// File: rtl/rx_decode.sv
module rx_decode
    import ism_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       adv,
    output sym_t       sym
);
    typedef struct packed {
        logic adv;
        sym_t sym;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d.adv = in_valid;
        for (int i = 0; i < NSYM; i++) begin
            dec_d.sym[i] = in_valid && (in_data == (SYM_BASE + 8'(i)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_d;
    end

    assign adv = dec_q.adv;
    assign sym = dec_q.sym;
endmodule

// File: rtl/seq_track.sv
module seq_track
    import ism_pkg::*;
#(
    parameter int LEN = 3,
    parameter logic [8*LEN-1:0] SEQ = "cde"
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  sym_t sym,
    output logic hit
);
    localparam int PW = LEN - 1;

    typedef struct packed {
        logic [PW-1:0] prog;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [LEN-1:0] ch_ok;

    for (genvar j = 0; j < LEN; j++) begin : g_ch
        localparam int S = int'(SEQ[8*(LEN-1-j) +: 8]) - int'(SYM_BASE);
        assign ch_ok[j] = sym[S];
    end

    always_comb begin
        trk_d = trk_q;
        if (adv) begin
            trk_d.prog[0] = ch_ok[0];
            for (int j = 1; j < PW; j++) begin
                trk_d.prog[j] = trk_q.prog[j-1] & ch_ok[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trk_q <= '0;
        else     trk_q <= trk_d;
    end

    assign hit = trk_q.prog[PW-1] & ch_ok[LEN-1];
endmodule

// File: rtl/pattern_lane.sv
module pattern_lane
    import ism_pkg::*;
#(
    parameter int PRE_LEN = 2,
    parameter logic [8*PRE_LEN-1:0] PRE_SEQ = "ab",
    parameter logic [7:0] SFX_CH = "f",
    parameter int K = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  sym_t sym,
    input  logic inf_hit,
    output logic match_o
);
    localparam int SS = int'(SFX_CH) - int'(SYM_BASE);

    typedef struct packed {
        logic [K-1:0] dly;
        logic         armed;
        logic         match;
    } lane_t;

    lane_t ln_d, ln_q;
    logic  pre_hit;
    logic  sfx_ok;

    seq_track #(.LEN(PRE_LEN), .SEQ(PRE_SEQ)) u_pre (
        .clk (clk),
        .rst (rst),
        .adv (adv),
        .sym (sym),
        .hit (pre_hit)
    );

    assign sfx_ok = sym[SS];

    always_comb begin
        ln_d = ln_q;
        ln_d.match = 1'b0;
        if (adv) begin
            ln_d.dly[0] = pre_hit;
            for (int i = 1; i < K; i++) begin
                ln_d.dly[i] = ln_q.dly[i-1];
            end
            ln_d.armed = ln_q.dly[K-1] & inf_hit;
            ln_d.match = ln_q.armed & sfx_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ln_q <= '0;
        else     ln_q <= ln_d;
    end

    assign match_o = ln_q.match;
endmodule

// File: rtl/hit_encoder.sv
module hit_encoder #(
    parameter int NPAT = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPAT-1:0]  vec_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [NPAT-1:0]  vec_o
);
    typedef struct packed {
        logic [NPAT-1:0]  vec;
        logic             valid;
        logic [IDX_W-1:0] idx;
    } enc_t;

    enc_t enc_d, enc_q;

    always_comb begin
        enc_d.vec   = vec_i;
        enc_d.valid = |vec_i;
        enc_d.idx   = '0;
        for (int i = NPAT - 1; i >= 0; i--) begin
            if (vec_i[i]) enc_d.idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) enc_q <= '0;
        else     enc_q <= enc_d;
    end

    assign valid_o = enc_q.valid;
    assign idx_o   = enc_q.idx;
    assign vec_o   = enc_q.vec;
endmodule

// File: rtl/infix_share_matcher.sv
module infix_share_matcher
    import ism_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             hit_valid,
    output logic [IDX_W-1:0] hit_idx,
    output logic [NPAT-1:0]  hit_vec
);
    logic            adv;
    sym_t            sym;
    logic            inf_hit;
    logic [NPAT-1:0] match;

    rx_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .adv      (adv),
        .sym      (sym)
    );

    seq_track #(.LEN(INF_LEN), .SEQ(INF_SEQ)) u_infix (
        .clk (clk),
        .rst (rst),
        .adv (adv),
        .sym (sym),
        .hit (inf_hit)
    );

    for (genvar g = 0; g < NPAT; g++) begin : g_lane
        pattern_lane #(
            .PRE_LEN (PRE_LEN),
            .PRE_SEQ (PRE_SEQS[g]),
            .SFX_CH  (SFX_CHARS[g]),
            .K       (INF_LEN)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .adv     (adv),
            .sym     (sym),
            .inf_hit (inf_hit),
            .match_o (match[g])
        );
    end

    hit_encoder #(.NPAT(NPAT), .IDX_W(IDX_W)) u_enc (
        .clk     (clk),
        .rst     (rst),
        .vec_i   (match),
        .valid_o (hit_valid),
        .idx_o   (hit_idx),
        .vec_o   (hit_vec)
    );
endmodule

// File: rtl/hit_chk.sv
module hit_chk #(
    parameter int NPAT = 2,
    parameter int IDX_W = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             hit_valid,
    input logic [IDX_W-1:0] hit_idx,
    input logic [NPAT-1:0]  hit_vec
);
    logic [1:0] warm_q;

    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!hit_valid && hit_vec == '0 && hit_idx == '0));

    // R6
    hit_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3 && hit_valid) |-> $past(in_valid, 3));

    // R7
    idx_points_at_flag_chk: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> hit_vec[hit_idx]);

    // R7
    quiet_when_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |-> (hit_vec == '0 && hit_idx == '0));

    // R2
    p0_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hit_vec[0] |=> !hit_vec[0]);

    // R3
    p1_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hit_vec[1] |=> !hit_vec[1]);
endmodule

bind infix_share_matcher hit_chk #(
    .NPAT  (ism_pkg::NPAT),
    .IDX_W (ism_pkg::IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .hit_valid (hit_valid),
    .hit_idx   (hit_idx),
    .hit_vec   (hit_vec)
);

// File: tb/infix_share_matcher_tb.sv
`timescale 1ns/1ps
module infix_share_matcher_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       hit_valid;
    logic [0:0] hit_idx;
    logic [1:0] hit_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    logic [7:0] hist [6];
    logic [1:0] p1 = '0, p2 = '0, p3 = '0;

    always #2.5 clk = ~clk;

    infix_share_matcher u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .hit_valid (hit_valid),
        .hit_idx   (hit_idx),
        .hit_vec   (hit_vec)
    );

    function automatic bit tail_is(string p);
        for (int i = 0; i < 6; i++) begin
            if (hist[i] != p[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [1:0] model_push(logic [7:0] c);
        for (int i = 0; i < 5; i++) hist[i] = hist[i+1];
        hist[5] = c;
        return {tail_is("cdcdeg"), tail_is("abcdef")};
    endfunction

    task automatic check_out(string req, logic [1:0] ev);
        logic       e_valid;
        logic [0:0] e_idx;
        e_valid = |ev;
        e_idx   = (ev[0] || !ev[1]) ? 1'b0 : 1'b1;
        n_chk++;
        if (hit_vec !== ev || hit_valid !== e_valid || hit_idx !== e_idx) begin
            n_bad++;
            $display("FAIL %s: vec=%b valid=%b idx=%0d expected vec=%b valid=%b idx=%0d",
                     req, hit_vec, hit_valid, hit_idx, ev, e_valid, e_idx);
        end
    endtask

    task automatic step(bit v, logic [7:0] c);
        logic [1:0] e;
        in_valid = v;
        in_data  = c;
        e = v ? model_push(c) : 2'b00;
        @(posedge clk);
        @(negedge clk);
        p3 = p2; p2 = p1; p1 = e;
        check_out(cur_req, p3);
    endtask

    task automatic send(string s, int gap);
        for (int i = 0; i < s.len(); i++) begin
            step(1'b1, s[i]);
            for (int g = 0; g < gap; g++) step(1'b0, 8'h00);
        end
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(1'b0, 8'h00);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while in reset
        check_out("R1", 2'b00);
        rst = 1'b0;
        p1 = '0; p2 = '0; p3 = '0;
        for (int i = 0; i < 6; i++) hist[i] = 8'h00;
    endtask

    initial begin
        int unsigned seed;
        int unsigned r;
        for (int i = 0; i < 6; i++) hist[i] = 8'h00;
        seed = $urandom(32'd7151);
        @(negedge clk);
        do_reset();
        cur_req = "R1";
        flush();

        cur_req = "R2"; send("abcdef", 0); flush();
        cur_req = "R3"; send("cdcdeg", 0); flush();
        cur_req = "R4"; send("abcdeg", 0); flush();
        cur_req = "R4"; send("cdcdef", 0); flush();
        cur_req = "R5"; send("cdcdcdeg", 0); flush();
        cur_req = "R5"; send("abcdefcdcdegabcdef", 0); flush();
        cur_req = "R6"; send("abcdef", 2); flush();
        cur_req = "R6"; send("cdcdeg", 1); flush();
        cur_req = "R8"; send("abcxdef", 0); flush();
        cur_req = "R8"; send("cdczdeg", 0); flush();

        // R1: partial progress must not survive a reset
        cur_req = "R1";
        send("abcde", 0);
        do_reset();
        send("f", 0); flush();
        send("cdcde", 0);
        do_reset();
        send("g", 0); flush();

        cur_req = "R2 R3 R7";
        for (int n = 0; n < 2500; n++) begin
            r = $urandom % 100;
            if (r < 12) begin
                step(1'b0, 8'h00);
            end else if (r < 16) begin
                send("abcdef", ($urandom % 4 == 0) ? 1 : 0);
            end else if (r < 20) begin
                send("cdcdeg", ($urandom % 4 == 0) ? 1 : 0);
            end else if (r < 23) begin
                send("abcdeg", 0);
            end else if (r < 25) begin
                step(1'b1, "z");
            end else begin
                step(1'b1, 8'("a" + ($urandom % 7)));
            end
        end
        flush();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule